// File: doc/BRIEF.md
# Register-Mapped SAR Conversion Sequencer

This block is the digital front end of a four-channel, 12-bit successive-approximation converter. Software reaches it over a plain 32-bit register bus with a byte address, a write strobe, write data and combinational read data. Through one control word it can power the converter down or up, pick the conversion clock, run a calibration pass, and launch either a one-shot pass or a repeating chain of conversions over the channels enabled in a mask.

The analog macro is modelled by two inputs: a 12-bit sample bus that is captured at the end of each conversion, and a pass/fail line that is read when calibration ends. A 3-bit state code, calibration busy and fail flags, per-channel result registers and write-one-to-clear interrupt flags let software track progress. An interrupt line is raised when an enabled flag is set.

Top module: `sar_seq_ctrl`

## Requirements
- R1: After reset the state code reads 1 (power-down), the control word at 0x00 reads 0x0000_0001, the flags at 0x10 and all results read 0, and irq is low.
- R2: While control bit 0 is 1 the state code becomes 1 on the next clock, even in the middle of a calibration or conversion, which is abandoned. One clock after bit 0 is cleared while the state reads 1, the state reads 0 (idle).
- R3: While the state reads 1 or control bit 0 is set, control bits 14 (calibrate) and 24 (start) read 0. Writes that set them then have no effect.
- R4: Control bit 8 (clock select) takes a written value only when the state reads 1. Writes at any other time leave it unchanged.
- R5: Setting bit 14 while idle gives state 3 with status bit 29 (busy) set for exactly 64 clocks. The block then returns to idle, clears bit 14, and sets status bit 30 to the inverse of cal_ok as sampled in the last calibration clock.
- R6: With control bit 29 at 0, setting bit 24 converts each channel whose bit is set in the mask at 0xA4 (bit n = channel n) once, in ascending channel order. It then returns to idle with bit 24 cleared. With an empty mask, bit 24 is cleared and nothing is converted.
- R7: Each channel spends 4 clocks in state 4 (sampling) and then 12 clocks in state 6 (converting). The sample input is captured on the last converting clock into bits [11:0] of the register at 0x100 + 4 × channel.
- R8: With control bit 29 at 1, the chain repeats with one clock of state 2 (wait) between passes for as long as bit 24 stays set. Once bit 24 is cleared, the current pass finishes and the block goes idle.
- R9: Flag register 0x10 bit 1 is set when a channel whose bit is set in 0x24 finishes converting. Bit 0 is set when the last channel of a pass finishes. Writing 1 to a bit clears it, and a new set in the same clock takes priority over the clear.
- R10: irq is high exactly when some flag bit at 0x10 and the bit in the same position of the enable register at 0x20 are both 1.
- R11: The state code only takes the values 0, 1, 2, 3, 4 and 6. Sampling is entered only from idle, wait or converting, and converting only from sampling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, captured on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| smp_data | input | 12 | Converter output, captured at the end of each conversion |
| cal_ok | input | 1 | Calibration result from the converter (1 = pass) |
| irq | output | 1 | Interrupt: an enabled flag is set |

## Verification
The one-shot path is tried with a single low channel, all four channels, two adjacent middle channels, only the top channel, two alternating channels and an empty mask. Together these separate a correct walk over the mask from one that skips, repeats or overruns it, and show which result registers must stay untouched. A two-channel run changes the sample value between the two captures, which exposes a descending or wrong-order walk. The same run samples the state code at the edges of the sampling and converting windows to catch an off-by-one count. Calibration runs with both pass and fail inputs, continuous mode is stopped partway through, and a power-down during a conversion shows whether activity is abandoned and pending requests are dropped.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_PWDN = 3'd1,
        ST_WAIT = 3'd2,
        ST_CAL  = 3'd3,
        ST_SAMP = 3'd4,
        ST_CONV = 3'd6
    } seq_state_e;

    // register byte offsets
    localparam int unsigned ADDR_CTRL  = 'h000;
    localparam int unsigned ADDR_STAT  = 'h004;
    localparam int unsigned ADDR_FLAG  = 'h010;
    localparam int unsigned ADDR_FEN   = 'h020;
    localparam int unsigned ADDR_CHIEN = 'h024;
    localparam int unsigned ADDR_CHSEL = 'h0A4;
    localparam int unsigned ADDR_DATA  = 'h100;

    // control word bit positions
    localparam int CB_PWDN   = 0;
    localparam int CB_CLKSEL = 8;
    localparam int CB_CAL    = 14;
    localparam int CB_START  = 24;
    localparam int CB_CONT   = 29;

    // status word bit positions
    localparam int SB_BUSY = 29;
    localparam int SB_FAIL = 30;

endpackage

// File: rtl/sar_chan_pick.sv
module sar_chan_pick #(
    parameter int NCH = 4,
    parameter int CHW = 2
) (
    input  logic [NCH-1:0] mask,
    input  logic [CHW-1:0] after,
    input  logic           from_first,
    output logic           found,
    output logic [CHW-1:0] pick
);

    logic [NCH-1:0] cand;

    for (genvar i = 0; i < NCH; i++) begin : g_cand
        assign cand[i] = mask[i] && (from_first || (int'(after) < i));
    end

    // lowest candidate wins: the descending walk lets lower indices overwrite
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (cand[i]) begin
                found = 1'b1;
                pick  = CHW'(i);
            end
        end
    end

endmodule

// File: rtl/sar_seq_fsm.sv
module sar_seq_fsm
    import sar_pkg::*;
#(
    parameter int NCH      = 4,
    parameter int SAMP_CYC = 4,
    parameter int CONV_CYC = 12,
    parameter int CAL_CYC  = 64
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           pwdn_req,
    input  logic                           cal_req,
    input  logic                           start_req,
    input  logic                           cont_mode,
    input  logic [NCH-1:0]                 chan_mask,
    input  logic                           cal_ok,
    output seq_state_e                     state,
    output logic [(NCH>1?$clog2(NCH):1)-1:0] cur_ch,
    output logic                           cal_fail,
    output logic                           conv_done,
    output logic                           chain_end,
    output logic                           cal_done,
    output logic                           start_clr
);

    localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int M1   = (SAMP_CYC > CONV_CYC) ? SAMP_CYC : CONV_CYC;
    localparam int MAXC = (M1 > CAL_CYC) ? M1 : CAL_CYC;
    localparam int CNTW = (MAXC > 1) ? $clog2(MAXC) : 1;

    typedef struct packed {
        seq_state_e      st;
        logic [CNTW-1:0] cnt;
        logic [CHW-1:0]  ch;
        logic            fail;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    logic           first_found, next_found;
    logic [CHW-1:0] first_pick, next_pick;

    sar_chan_pick #(.NCH(NCH), .CHW(CHW)) u_pick_first (
        .mask(chan_mask), .after(fsm_q.ch), .from_first(1'b1),
        .found(first_found), .pick(first_pick)
    );

    sar_chan_pick #(.NCH(NCH), .CHW(CHW)) u_pick_next (
        .mask(chan_mask), .after(fsm_q.ch), .from_first(1'b0),
        .found(next_found), .pick(next_pick)
    );

    always_comb begin
        fsm_d     = fsm_q;
        conv_done = 1'b0;
        chain_end = 1'b0;
        cal_done  = 1'b0;
        start_clr = 1'b0;
        if (pwdn_req) begin
            fsm_d.st  = ST_PWDN;
            fsm_d.cnt = '0;
        end else begin
            unique case (fsm_q.st)
                ST_PWDN: begin
                    fsm_d.st  = ST_IDLE;
                    fsm_d.cnt = '0;
                end
                ST_IDLE: begin
                    if (cal_req) begin
                        fsm_d.st  = ST_CAL;
                        fsm_d.cnt = '0;
                    end else if (start_req) begin
                        if (first_found) begin
                            fsm_d.st  = ST_SAMP;
                            fsm_d.ch  = first_pick;
                            fsm_d.cnt = '0;
                        end else begin
                            start_clr = 1'b1;
                        end
                    end
                end
                ST_CAL: begin
                    if (fsm_q.cnt == CNTW'(CAL_CYC - 1)) begin
                        fsm_d.st   = ST_IDLE;
                        fsm_d.cnt  = '0;
                        fsm_d.fail = ~cal_ok;
                        cal_done   = 1'b1;
                    end else begin
                        fsm_d.cnt = fsm_q.cnt + 1'b1;
                    end
                end
                ST_SAMP: begin
                    if (fsm_q.cnt == CNTW'(SAMP_CYC - 1)) begin
                        fsm_d.st  = ST_CONV;
                        fsm_d.cnt = '0;
                    end else begin
                        fsm_d.cnt = fsm_q.cnt + 1'b1;
                    end
                end
                ST_CONV: begin
                    if (fsm_q.cnt == CNTW'(CONV_CYC - 1)) begin
                        conv_done = 1'b1;
                        fsm_d.cnt = '0;
                        if (next_found) begin
                            fsm_d.st = ST_SAMP;
                            fsm_d.ch = next_pick;
                        end else begin
                            chain_end = 1'b1;
                            if (cont_mode && start_req) begin
                                fsm_d.st = ST_WAIT;
                            end else begin
                                fsm_d.st  = ST_IDLE;
                                start_clr = 1'b1;
                            end
                        end
                    end else begin
                        fsm_d.cnt = fsm_q.cnt + 1'b1;
                    end
                end
                ST_WAIT: begin
                    if (start_req && first_found) begin
                        fsm_d.st  = ST_SAMP;
                        fsm_d.ch  = first_pick;
                        fsm_d.cnt = '0;
                    end else begin
                        fsm_d.st  = ST_IDLE;
                        start_clr = 1'b1;
                    end
                end
                default: fsm_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q <= '{st: ST_PWDN, cnt: '0, ch: '0, fail: 1'b0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign state    = fsm_q.st;
    assign cur_ch   = fsm_q.ch;
    assign cal_fail = fsm_q.fail;

endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
    import sar_pkg::*;
#(
    parameter int NCH      = 4,
    parameter int DW       = 12,
    parameter int AW       = 12,
    parameter int SAMP_CYC = 4,
    parameter int CONV_CYC = 12,
    parameter int CAL_CYC  = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_we,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    input  logic [DW-1:0] smp_data,
    input  logic          cal_ok,
    output logic          irq
);

    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;

    typedef struct packed {
        logic                    pwdn;
        logic                    clksel;
        logic                    cal;
        logic                    start;
        logic                    cont;
        logic [NCH-1:0]          chsel;
        logic [NCH-1:0]          chien;
        logic [1:0]              fen;
        logic [1:0]              flag;
        logic [NCH-1:0][DW-1:0]  data;
    } regs_t;

    regs_t r_d, r_q;

    seq_state_e     seq_st;
    logic [CHW-1:0] cur_ch;
    logic           cal_fail, conv_done, chain_end, cal_done, start_clr;

    // plain copies for the bound checker
    logic [2:0] st_code;
    logic       pwdn_bit, clksel_bit, cal_bit, start_bit, cal_busy;

    sar_seq_fsm #(
        .NCH(NCH), .SAMP_CYC(SAMP_CYC), .CONV_CYC(CONV_CYC), .CAL_CYC(CAL_CYC)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .pwdn_req(r_q.pwdn), .cal_req(r_q.cal), .start_req(r_q.start),
        .cont_mode(r_q.cont), .chan_mask(r_q.chsel), .cal_ok(cal_ok),
        .state(seq_st), .cur_ch(cur_ch), .cal_fail(cal_fail),
        .conv_done(conv_done), .chain_end(chain_end),
        .cal_done(cal_done), .start_clr(start_clr)
    );

    logic powered_down;
    logic wr_ctrl, wr_flag, wr_fen, wr_chien, wr_chsel;

    assign powered_down = (seq_st == ST_PWDN);
    assign wr_ctrl  = bus_we && (bus_addr == AW'(ADDR_CTRL));
    assign wr_flag  = bus_we && (bus_addr == AW'(ADDR_FLAG));
    assign wr_fen   = bus_we && (bus_addr == AW'(ADDR_FEN));
    assign wr_chien = bus_we && (bus_addr == AW'(ADDR_CHIEN));
    assign wr_chsel = bus_we && (bus_addr == AW'(ADDR_CHSEL));

    always_comb begin
        r_d = r_q;
        // sequencer completions retire their requests
        if (cal_done)  r_d.cal   = 1'b0;
        if (start_clr) r_d.start = 1'b0;
        if (wr_ctrl) begin
            r_d.pwdn  = bus_wdata[CB_PWDN];
            r_d.cal   = bus_wdata[CB_CAL];
            r_d.start = bus_wdata[CB_START];
            r_d.cont  = bus_wdata[CB_CONT];
            if (powered_down) r_d.clksel = bus_wdata[CB_CLKSEL];
        end
        // no requests survive while the converter is off
        if (r_q.pwdn || r_d.pwdn || powered_down) begin
            r_d.cal   = 1'b0;
            r_d.start = 1'b0;
        end
        if (wr_fen)   r_d.fen   = bus_wdata[1:0];
        if (wr_chien) r_d.chien = bus_wdata[NCH-1:0];
        if (wr_chsel) r_d.chsel = bus_wdata[NCH-1:0];
        if (wr_flag)  r_d.flag  = r_q.flag & ~bus_wdata[1:0];
        if (conv_done) begin
            r_d.data[cur_ch] = smp_data;
            if (r_q.chien[cur_ch]) r_d.flag[1] = 1'b1;
        end
        if (chain_end) r_d.flag[0] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.pwdn <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == AW'(ADDR_CTRL)) begin
            bus_rdata[CB_PWDN]   = r_q.pwdn;
            bus_rdata[CB_CLKSEL] = r_q.clksel;
            bus_rdata[CB_CAL]    = r_q.cal;
            bus_rdata[CB_START]  = r_q.start;
            bus_rdata[CB_CONT]   = r_q.cont;
        end else if (bus_addr == AW'(ADDR_STAT)) begin
            bus_rdata[2:0]     = seq_st;
            bus_rdata[SB_BUSY] = (seq_st == ST_CAL);
            bus_rdata[SB_FAIL] = cal_fail;
        end else if (bus_addr == AW'(ADDR_FLAG)) begin
            bus_rdata[1:0] = r_q.flag;
        end else if (bus_addr == AW'(ADDR_FEN)) begin
            bus_rdata[1:0] = r_q.fen;
        end else if (bus_addr == AW'(ADDR_CHIEN)) begin
            bus_rdata[NCH-1:0] = r_q.chien;
        end else if (bus_addr == AW'(ADDR_CHSEL)) begin
            bus_rdata[NCH-1:0] = r_q.chsel;
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if (bus_addr == AW'(ADDR_DATA + 4 * i)) bus_rdata[DW-1:0] = r_q.data[i];
            end
        end
    end

    assign irq        = |(r_q.flag & r_q.fen);
    assign st_code    = seq_st;
    assign pwdn_bit   = r_q.pwdn;
    assign clksel_bit = r_q.clksel;
    assign cal_bit    = r_q.cal;
    assign start_bit  = r_q.start;
    assign cal_busy   = (seq_st == ST_CAL);

endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] st_code,
    input logic       pwdn_bit,
    input logic       clksel_bit,
    input logic       cal_bit,
    input logic       start_bit,
    input logic       cal_busy
);

    // R11
    legal_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_code inside {3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd6});

    // R2
    pwdn_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwdn_bit |=> (st_code == 3'd1));

    // R3
    pwdn_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_code == 3'd1) |-> (!start_bit && !cal_bit));

    // R4
    clksel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_code != 3'd1) |=> $stable(clksel_bit));

    // R11
    samp_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_code == 3'd4) && ($past(st_code) != 3'd4))
            |-> ($past(st_code) inside {3'd0, 3'd2, 3'd6}));

    // R11
    conv_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_code == 3'd6) && ($past(st_code) != 3'd6)) |-> ($past(st_code) == 3'd4));

    // R5
    cal_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cal_busy) |-> (st_code inside {3'd0, 3'd1}));

endmodule

bind sar_seq_ctrl sar_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .st_code(st_code), .pwdn_bit(pwdn_bit),
    .clksel_bit(clksel_bit), .cal_bit(cal_bit), .start_bit(start_bit),
    .cal_busy(cal_busy)
);

// File: tb/tb_sar_seq_ctrl.sv
module tb_sar_seq_ctrl;

    localparam int HALF = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [11:0] smp_data = '0;
    logic        cal_ok = 1'b1;
    logic        irq;

    int n_run = 0;
    int n_fail = 0;
    logic [11:0] model [4];

    always #HALF clk = ~clk;

    sar_seq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .smp_data(smp_data),
        .cal_ok(cal_ok), .irq(irq)
    );

    // mask in [15:12], sample value in [11:0]
    localparam logic [15:0] VEC [0:5] = '{
        16'h1123, 16'hFABC, 16'h65A5, 16'h8FFF, 16'h5000, 16'h0777
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic wait_idle(input string req);
        logic [31:0] v;
        bit done = 0;
        for (int i = 0; i < 3000 && !done; i++) begin
            @(negedge clk);
            rd(12'h004, v);
            if (v[2:0] == 3'd0) done = 1;
        end
        chk(req, {31'd0, done}, 32'd1);
    endtask

    task automatic chk_data(input string req);
        logic [31:0] v;
        for (int c = 0; c < 4; c++) begin
            rd(12'(12'h100 + 4 * c), v);
            chk(req, v, {20'd0, model[c]});
        end
    endtask

    initial begin
        #(HALF * 2 * 150000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        bit seen_wait;
        for (int c = 0; c < 4; c++) model[c] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        rd(12'h004, v); chk("R1 state", {29'd0, v[2:0]}, 32'd1);
        rd(12'h000, v); chk("R1 ctrl", v, 32'h0000_0001);
        rd(12'h010, v); chk("R1 flags", v, 32'd0);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk_data("R1 data");

        // R3 start and calibrate dropped while powered down
        wr(12'h000, 32'h0100_4001);
        @(negedge clk);
        rd(12'h000, v); chk("R3 ctrl", v, 32'h0000_0001);
        rd(12'h004, v); chk("R3 state", {29'd0, v[2:0]}, 32'd1);

        // R4 clock select accepted while powered down
        wr(12'h000, 32'h0000_0101);
        rd(12'h000, v); chk("R4 set", v, 32'h0000_0101);

        // R2 power up takes one clock
        wr(12'h000, 32'h0000_0100);
        rd(12'h004, v); chk("R2 still down", {29'd0, v[2:0]}, 32'd1);
        @(negedge clk);
        rd(12'h004, v); chk("R2 idle", {29'd0, v[2:0]}, 32'd0);

        // R4 clock select write dropped while idle
        wr(12'h000, 32'h0000_0000);
        rd(12'h000, v); chk("R4 hold", v, 32'h0000_0100);

        // R5 calibration with failing input
        cal_ok = 1'b0;
        wr(12'h000, 32'h0000_4100);
        @(negedge clk);
        rd(12'h004, v); chk("R5 busy start", v, 32'h2000_0003);
        repeat (63) @(negedge clk);
        rd(12'h004, v); chk("R5 busy last", v, 32'h2000_0003);
        @(negedge clk);
        rd(12'h004, v); chk("R5 fail", v, 32'h4000_0000);
        rd(12'h000, v); chk("R5 bit clear", v, 32'h0000_0100);

        // R5 calibration with passing input
        cal_ok = 1'b1;
        wr(12'h000, 32'h0000_4100);
        repeat (70) @(negedge clk);
        rd(12'h004, v); chk("R5 pass", v, 32'h0000_0000);

        // R6 R9 one-shot table
        wr(12'h024, 32'h0000_000F);
        wr(12'h020, 32'h0000_0000);
        for (int k = 0; k < 6; k++) begin
            logic [3:0] m;
            m = VEC[k][15:12];
            wr(12'h0A4, {28'd0, m});
            smp_data = VEC[k][11:0];
            wr(12'h000, 32'h0100_0100);
            repeat (2) @(negedge clk);
            wait_idle("R6 done");
            for (int c = 0; c < 4; c++) if (m[c]) model[c] = VEC[k][11:0];
            chk_data("R6 data");
            rd(12'h000, v); chk("R6 start cleared", v, 32'h0000_0100);
            rd(12'h010, v); chk("R9 flags", v, (m != 0) ? 32'd3 : 32'd0);
            wr(12'h010, 32'h0000_0003);
            rd(12'h010, v); chk("R9 w1c", v, 32'd0);
        end

        // R7 window timing and R6 ascending order
        wr(12'h0A4, 32'h0000_000A);
        smp_data = 12'h111;
        wr(12'h000, 32'h0100_0100);
        @(negedge clk);
        rd(12'h004, v); chk("R7 sample first", {29'd0, v[2:0]}, 32'd4);
        repeat (3) @(negedge clk);
        rd(12'h004, v); chk("R7 sample last", {29'd0, v[2:0]}, 32'd4);
        @(negedge clk);
        rd(12'h004, v); chk("R7 conv first", {29'd0, v[2:0]}, 32'd6);
        repeat (11) @(negedge clk);
        rd(12'h004, v); chk("R7 conv last", {29'd0, v[2:0]}, 32'd6);
        @(negedge clk);
        rd(12'h104, v); chk("R7 capture", v, 32'h0000_0111);
        smp_data = 12'h222;
        wait_idle("R6 order done");
        model[1] = 12'h111; model[3] = 12'h222;
        chk_data("R6 order");
        wr(12'h010, 32'h0000_0003);

        // R9 per-channel enable gates bit 1 only
        wr(12'h024, 32'h0000_0001);
        wr(12'h0A4, 32'h0000_0002);
        smp_data = 12'h333;
        wr(12'h000, 32'h0100_0100);
        repeat (2) @(negedge clk);
        wait_idle("R9 run");
        rd(12'h010, v); chk("R9 chan enable", v, 32'd1);
        model[1] = 12'h333;
        wr(12'h010, 32'h0000_0003);

        // R10 interrupt gating
        wr(12'h024, 32'h0000_000F);
        wr(12'h020, 32'h0000_0002);
        wr(12'h0A4, 32'h0000_0001);
        wr(12'h000, 32'h0100_0100);
        repeat (2) @(negedge clk);
        wait_idle("R10 run");
        model[0] = 12'h333;
        chk("R10 irq eoc", {31'd0, irq}, 32'd1);
        wr(12'h020, 32'h0000_0000);
        chk("R10 irq masked", {31'd0, irq}, 32'd0);
        wr(12'h020, 32'h0000_0001);
        chk("R10 irq chain", {31'd0, irq}, 32'd1);
        wr(12'h010, 32'h0000_0001);
        chk("R10 irq cleared", {31'd0, irq}, 32'd0);
        rd(12'h010, v); chk("R9 partial clear", v, 32'd2);
        wr(12'h010, 32'h0000_0003);
        wr(12'h020, 32'h0000_0000);

        // R8 continuous mode
        smp_data = 12'h0AA;
        wr(12'h000, 32'h2100_0100);
        seen_wait = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            rd(12'h004, v);
            if (v[2:0] == 3'd2) seen_wait = 1;
        end
        chk("R8 wait seen", {31'd0, seen_wait}, 32'd1);
        rd(12'h004, v); chk("R8 running", {31'd0, (v[2:0] != 3'd0)}, 32'd1);
        smp_data = 12'h0BB;
        repeat (25) @(negedge clk);
        rd(12'h100, v); chk("R8 repeat capture", v, 32'h0000_00BB);
        wr(12'h000, 32'h2000_0100);
        wait_idle("R8 stop");
        model[0] = 12'h0BB;
        rd(12'h000, v); chk("R8 start low", v, 32'h2000_0100);
        chk_data("R8 data");
        wr(12'h010, 32'h0000_0003);

        // R2 power-down abandons a running pass
        wr(12'h000, 32'h0000_0100);
        wr(12'h0A4, 32'h0000_000F);
        smp_data = 12'h444;
        wr(12'h000, 32'h0100_0100);
        repeat (5) @(negedge clk);
        wr(12'h000, 32'h0100_0101);
        @(negedge clk);
        rd(12'h004, v); chk("R2 abort state", {29'd0, v[2:0]}, 32'd1);
        rd(12'h000, v); chk("R3 start dropped", v, 32'h0000_0101);
        repeat (30) @(negedge clk);
        rd(12'h004, v); chk("R2 stays down", {29'd0, v[2:0]}, 32'd1);
        chk_data("R2 no capture");

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule